// File: doc/BRIEF.md
# Speculative Load Deferred-Exception Tracker

This block lets a compiler hoist a load above a branch. The load is split into two operations. A speculative load is issued early and performs the memory access. A check operation stays at the load's original place in the program. If the speculative access faults, the fault is not raised. Instead, the destination register receives zero and a one-bit deferred-fault token is recorded against that register. A later check on the register raises the exception only if the token is present, and then consumes the token. If the token is absent, the check does nothing. A faulting ordinary (non-speculative) load still traps at once.

The block forwards each load request to memory with a tag. The tag identifies the destination register and the load kind, and memory returns it with the response. The block then produces the register write-back and maintains one token per general register. Any ordinary write to a register removes that register's token. Two exception outputs are provided, each a one-cycle pulse carrying a register index. One reports an immediate trap from a faulting ordinary load. The other reports a deferred fault raised by a check.

Top module: `spec_load_tracker`

## Requirements
- R1: A load request is forwarded to memory combinationally. mem_req_o follows ld_valid_i and mem_addr_o follows ld_addr_i. mem_tag_o bit 7 is the kind (1 = speculative, 0 = ordinary) and bits 6:0 are the destination register.
- R2: A response with mem_rsp_fault_i = 1 and tag bit 7 = 1 produces, one cycle later, wb_valid_o = 1, wb_reg_o = tag bits 6:0 and wb_data_o = 0. It produces no ld_exc_o.
- R3: A speculative faulting response sets the token of its register. A later check on that register gives chk_exc_o = 1 with chk_exc_reg_o equal to the register, for exactly the one cycle after the check.
- R4: A check on a register whose token is clear produces no exception.
- R5: A check consumes the token, so a second check on the same register raises nothing.
- R6: A faulting response with tag bit 7 = 0 gives, one cycle later, ld_exc_o = 1 with ld_exc_reg_o equal to the register. It produces no write-back and leaves that register's token unchanged.
- R7: A non-faulting response of either kind writes mem_rsp_data_i to its register one cycle later and clears that register's token.
- R8: An ordinary register write on gpr_wr_valid_i / gpr_wr_reg_i clears that register's token.
- R9: A check reads the token as it stood before the current cycle. If, in the same cycle, a clear and a speculative fault target the same register, the token ends set.
- R10: After reset, all outputs are low and every token is clear.
- R11: Tokens are independent per register, including registers 0 and 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | Load issue |
| ld_spec_i | input | 1 | Load is speculative |
| ld_dst_i | input | 7 | Load destination register |
| ld_addr_i | input | 64 | Load address |
| mem_req_o | output | 1 | Memory request valid |
| mem_addr_o | output | 64 | Memory request address |
| mem_tag_o | output | 8 | Request tag {kind, register} |
| mem_rsp_valid_i | input | 1 | Memory response valid |
| mem_rsp_tag_i | input | 8 | Returned tag |
| mem_rsp_data_i | input | 64 | Response data |
| mem_rsp_fault_i | input | 1 | Access raised a fault |
| gpr_wr_valid_i | input | 1 | Ordinary register write from another unit |
| gpr_wr_reg_i | input | 7 | Register written |
| chk_valid_i | input | 1 | Check operation |
| chk_reg_i | input | 7 | Register checked |
| wb_valid_o | output | 1 | Load write-back valid |
| wb_reg_o | output | 7 | Write-back register |
| wb_data_o | output | 64 | Write-back data |
| ld_exc_o | output | 1 | Immediate load trap pulse |
| ld_exc_reg_o | output | 7 | Register of the trapping load |
| chk_exc_o | output | 1 | Deferred exception pulse from a check |
| chk_exc_reg_o | output | 7 | Register whose check raised it |

## Verification
A check and an update of the same register's token can fall in the same cycle. The update is either a clear from a write or successful response, or a set from a speculative fault. Directed cycles drive a check together with an ordinary write, and a check together with a speculative fault, on the same register. A follow-up check then reveals the token that remained. A random phase then confines all traffic to eight registers so that such collisions occur often. Every cycle is judged against a reference model in which a check reads the old token, clears are applied next and sets are applied last.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int unsigned NUM_GPR = 128;
  localparam int unsigned XLEN    = 64;

  typedef enum logic {
    LD_NORMAL = 1'b0,
    LD_SPEC   = 1'b1
  } ld_kind_e;
endpackage

// File: rtl/sld_flag_file.sv
module sld_flag_file #(
  parameter int unsigned N_REGS = sld_pkg::NUM_GPR,
  parameter int unsigned REG_W  = $clog2(N_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_valid_i,
  input  logic [REG_W-1:0] set_reg_i,
  input  logic             clr_a_valid_i,
  input  logic [REG_W-1:0] clr_a_reg_i,
  input  logic             clr_b_valid_i,
  input  logic [REG_W-1:0] clr_b_reg_i,
  input  logic             chk_valid_i,
  input  logic [REG_W-1:0] chk_reg_i,
  output logic             chk_exc_o,
  output logic [REG_W-1:0] chk_exc_reg_o
);
  logic [N_REGS-1:0] flag_q, flag_d;

  for (genvar g = 0; g < N_REGS; g++) begin : g_flag
    logic hit_set, hit_clr;
    assign hit_set = set_valid_i && (set_reg_i == REG_W'(g));
    assign hit_clr = (clr_a_valid_i && (clr_a_reg_i == REG_W'(g)))
                  || (clr_b_valid_i && (clr_b_reg_i == REG_W'(g)))
                  || (chk_valid_i   && (chk_reg_i   == REG_W'(g)));
    // set beats any clear in the same cycle
    assign flag_d[g] = hit_set | (flag_q[g] & ~hit_clr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q        <= '0;
      chk_exc_o     <= 1'b0;
      chk_exc_reg_o <= '0;
    end else begin
      flag_q        <= flag_d;
      chk_exc_o     <= chk_valid_i && flag_q[chk_reg_i];
      chk_exc_reg_o <= chk_reg_i;
    end
  end

  // R3
  fault_sets_token_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_valid_i |=> flag_q[$past(set_reg_i)]);

  // R5
  check_consumes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_valid_i && !(set_valid_i && set_reg_i == chk_reg_i)) |=> !flag_q[$past(chk_reg_i)]);

  // R3
  chk_exc_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_exc_o |-> ($past(chk_valid_i) && chk_exc_reg_o == $past(chk_reg_i)));

  // R8
  write_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_a_valid_i && !(set_valid_i && set_reg_i == clr_a_reg_i)) |=> !flag_q[$past(clr_a_reg_i)]);
endmodule

// File: rtl/sld_rsp_stage.sv
module sld_rsp_stage
  import sld_pkg::*;
#(
  parameter int unsigned XLEN_P = sld_pkg::XLEN,
  parameter int unsigned REG_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rsp_valid_i,
  input  logic [REG_W:0]    rsp_tag_i,
  input  logic [XLEN_P-1:0] rsp_data_i,
  input  logic              rsp_fault_i,
  output logic              set_valid_o,
  output logic              clr_valid_o,
  output logic [REG_W-1:0]  rsp_reg_o,
  output logic              wb_valid_o,
  output logic [REG_W-1:0]  wb_reg_o,
  output logic [XLEN_P-1:0] wb_data_o,
  output logic              ld_exc_o,
  output logic [REG_W-1:0]  ld_exc_reg_o
);
  ld_kind_e kind;
  logic     trap;

  assign kind        = ld_kind_e'(rsp_tag_i[REG_W]);
  assign rsp_reg_o   = rsp_tag_i[REG_W-1:0];
  assign set_valid_o = rsp_valid_i && rsp_fault_i && (kind == LD_SPEC);
  assign trap        = rsp_valid_i && rsp_fault_i && (kind == LD_NORMAL);
  assign clr_valid_o = rsp_valid_i && !rsp_fault_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_valid_o   <= 1'b0;
      wb_reg_o     <= '0;
      wb_data_o    <= '0;
      ld_exc_o     <= 1'b0;
      ld_exc_reg_o <= '0;
    end else begin
      wb_valid_o   <= clr_valid_o || set_valid_o;
      wb_reg_o     <= rsp_reg_o;
      wb_data_o    <= rsp_fault_i ? '0 : rsp_data_i;
      ld_exc_o     <= trap;
      ld_exc_reg_o <= rsp_reg_o;
    end
  end

  // R6
  trap_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_exc_o |-> ($past(rsp_valid_i && rsp_fault_i) && !$past(rsp_tag_i[REG_W])));

  // R2
  zero_on_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && $past(rsp_fault_i)) |-> (wb_data_o == '0));

  // R6
  trap_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && rsp_fault_i && !rsp_tag_i[REG_W]) |=> !wb_valid_o);
endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker
  import sld_pkg::*;
#(
  parameter int unsigned N_REGS = sld_pkg::NUM_GPR,
  parameter int unsigned XLEN_P = sld_pkg::XLEN,
  parameter int unsigned AW     = 64,
  parameter int unsigned REG_W  = $clog2(N_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic              ld_spec_i,
  input  logic [REG_W-1:0]  ld_dst_i,
  input  logic [AW-1:0]     ld_addr_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [REG_W:0]    mem_tag_o,
  input  logic              mem_rsp_valid_i,
  input  logic [REG_W:0]    mem_rsp_tag_i,
  input  logic [XLEN_P-1:0] mem_rsp_data_i,
  input  logic              mem_rsp_fault_i,
  input  logic              gpr_wr_valid_i,
  input  logic [REG_W-1:0]  gpr_wr_reg_i,
  input  logic              chk_valid_i,
  input  logic [REG_W-1:0]  chk_reg_i,
  output logic              wb_valid_o,
  output logic [REG_W-1:0]  wb_reg_o,
  output logic [XLEN_P-1:0] wb_data_o,
  output logic              ld_exc_o,
  output logic [REG_W-1:0]  ld_exc_reg_o,
  output logic              chk_exc_o,
  output logic [REG_W-1:0]  chk_exc_reg_o
);
  logic             rsp_set, rsp_clr;
  logic [REG_W-1:0] rsp_reg;

  // tag travels with the request; no in-flight state kept here
  assign mem_req_o  = ld_valid_i;
  assign mem_addr_o = ld_addr_i;
  assign mem_tag_o  = {ld_spec_i, ld_dst_i};

  sld_rsp_stage #(.XLEN_P(XLEN_P), .REG_W(REG_W)) i_rsp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rsp_valid_i  (mem_rsp_valid_i),
    .rsp_tag_i    (mem_rsp_tag_i),
    .rsp_data_i   (mem_rsp_data_i),
    .rsp_fault_i  (mem_rsp_fault_i),
    .set_valid_o  (rsp_set),
    .clr_valid_o  (rsp_clr),
    .rsp_reg_o    (rsp_reg),
    .wb_valid_o   (wb_valid_o),
    .wb_reg_o     (wb_reg_o),
    .wb_data_o    (wb_data_o),
    .ld_exc_o     (ld_exc_o),
    .ld_exc_reg_o (ld_exc_reg_o)
  );

  sld_flag_file #(.N_REGS(N_REGS), .REG_W(REG_W)) i_flags (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .set_valid_i   (rsp_set),
    .set_reg_i     (rsp_reg),
    .clr_a_valid_i (gpr_wr_valid_i),
    .clr_a_reg_i   (gpr_wr_reg_i),
    .clr_b_valid_i (rsp_clr),
    .clr_b_reg_i   (rsp_reg),
    .chk_valid_i   (chk_valid_i),
    .chk_reg_i     (chk_reg_i),
    .chk_exc_o     (chk_exc_o),
    .chk_exc_reg_o (chk_exc_reg_o)
  );

  // R10
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !(wb_valid_o || ld_exc_o || chk_exc_o));
endmodule

// File: tb/test_spec_load_tracker.sv
`timescale 1ns/1ps
module test_spec_load_tracker;
  localparam int NR = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid, ld_spec;
  logic [6:0]  ld_dst;
  logic [63:0] ld_addr;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic [7:0]  mem_tag;
  logic        rsp_v;
  logic [7:0]  rsp_tag;
  logic [63:0] rsp_data;
  logic        rsp_fault;
  logic        gw_v;
  logic [6:0]  gw_reg;
  logic        ck_v;
  logic [6:0]  ck_reg;
  logic        wb_v;
  logic [6:0]  wb_reg;
  logic [63:0] wb_data;
  logic        le_v;
  logic [6:0]  le_reg;
  logic        ce_v;
  logic [6:0]  ce_reg;

  always #2 clk = ~clk;

  spec_load_tracker i_spec_load_tracker (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_valid_i(ld_valid), .ld_spec_i(ld_spec), .ld_dst_i(ld_dst), .ld_addr_i(ld_addr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_tag_o(mem_tag),
    .mem_rsp_valid_i(rsp_v), .mem_rsp_tag_i(rsp_tag), .mem_rsp_data_i(rsp_data),
    .mem_rsp_fault_i(rsp_fault),
    .gpr_wr_valid_i(gw_v), .gpr_wr_reg_i(gw_reg),
    .chk_valid_i(ck_v), .chk_reg_i(ck_reg),
    .wb_valid_o(wb_v), .wb_reg_o(wb_reg), .wb_data_o(wb_data),
    .ld_exc_o(le_v), .ld_exc_reg_o(le_reg),
    .chk_exc_o(ce_v), .chk_exc_reg_o(ce_reg)
  );

  bit    tok [NR];
  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R10";

  task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ld_valid = 0; ld_spec = 0; ld_dst = 0; ld_addr = 0;
    rsp_v = 0; rsp_tag = 0; rsp_data = 0; rsp_fault = 0;
    gw_v = 0; gw_reg = 0; ck_v = 0; ck_reg = 0;
  endtask

  // inputs already driven; model the cycle, then compare after the edge
  task automatic step();
    bit          e_wb, e_le, e_ce;
    logic [6:0]  r;
    logic [63:0] e_data;
    #1;
    cmp("R1", "mem_req", mem_req, ld_valid);
    if (ld_valid) begin
      cmp("R1", "mem_addr", mem_addr, ld_addr);
      cmp("R1", "mem_tag", mem_tag, {ld_spec, ld_dst});
    end
    r      = rsp_tag[6:0];
    e_ce   = ck_v && tok[ck_reg];
    e_wb   = rsp_v && !(rsp_fault && !rsp_tag[7]);
    e_le   = rsp_v && rsp_fault && !rsp_tag[7];
    e_data = rsp_fault ? 64'd0 : rsp_data;
    if (gw_v) tok[gw_reg] = 0;
    if (ck_v) tok[ck_reg] = 0;
    if (rsp_v && !rsp_fault) tok[r] = 0;
    if (rsp_v && rsp_fault && rsp_tag[7]) tok[r] = 1;
    begin
      logic [6:0] ck_snap = ck_reg;
      @(negedge clk);
      cmp(cur_req, "wb_valid", wb_v, e_wb);
      if (e_wb) begin
        cmp(cur_req, "wb_reg", wb_reg, r);
        cmp(cur_req, "wb_data", wb_data, e_data);
      end
      cmp(cur_req, "ld_exc", le_v, e_le);
      if (e_le) cmp(cur_req, "ld_exc_reg", le_reg, r);
      cmp(cur_req, "chk_exc", ce_v, e_ce);
      if (e_ce) cmp(cur_req, "chk_exc_reg", ce_reg, ck_snap);
    end
    idle();
  endtask

  task automatic resp(bit spec, int reg_n, bit fault, logic [63:0] d);
    rsp_v = 1; rsp_tag = {spec, 7'(reg_n)}; rsp_fault = fault; rsp_data = d;
  endtask

  task automatic check(int reg_n);
    ck_v = 1; ck_reg = 7'(reg_n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle();
    for (int i = 0; i < NR; i++) tok[i] = 0;
    repeat (3) @(negedge clk);
    // R10: quiet during reset
    cmp("R10", "wb_valid", wb_v, 0);
    cmp("R10", "ld_exc", le_v, 0);
    cmp("R10", "chk_exc", ce_v, 0);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R10";
    check(0);   step();
    check(127); step();
    check(64);  step();

    // R2 / R3: speculative fault, zero write-back, deferred report
    cur_req = "R2";
    ld_valid = 1; ld_spec = 1; ld_dst = 5; ld_addr = 64'h1000;
    resp(1, 5, 1, 64'hdead_beef); step();
    cur_req = "R3";
    check(5); step();
    step();   // pulse lasts one cycle only
    cur_req = "R5";
    check(5); step();
    cur_req = "R4";
    check(9); step();

    // R6: ordinary fault traps, leaves tokens alone
    cur_req = "R6";
    ld_valid = 1; ld_spec = 0; ld_dst = 12; ld_addr = 64'h2008;
    resp(0, 12, 1, 64'h1234); step();
    check(12); step();
    resp(1, 20, 1, 64'h0); step();
    resp(0, 20, 1, 64'h5); step();
    check(20); step();

    // R7: successful responses write data and clear
    cur_req = "R7";
    resp(1, 30, 1, 64'h0); step();
    resp(1, 30, 0, 64'hcafe_f00d_0000_0001); step();
    check(30); step();
    resp(1, 31, 1, 64'h0); step();
    resp(0, 31, 0, 64'h7777); step();
    check(31); step();

    // R8: ordinary write clears
    cur_req = "R8";
    resp(1, 40, 1, 64'h0); step();
    gw_v = 1; gw_reg = 40; step();
    check(40); step();

    // R9: same-cycle collisions
    cur_req = "R9";
    resp(1, 50, 1, 64'h0); step();
    check(50); gw_v = 1; gw_reg = 50; step();
    check(50); step();
    check(51); resp(1, 51, 1, 64'h0); step();
    check(51); step();
    resp(1, 52, 1, 64'h0); step();
    check(52); resp(1, 52, 1, 64'h0); step();
    check(52); step();

    // R11: independence, edge registers
    cur_req = "R11";
    resp(1, 0, 1, 64'h0); step();
    resp(1, 127, 1, 64'h0); step();
    check(1); step();
    check(126); step();
    check(127); step();
    check(0); step();

    // random traffic on few registers to force collisions
    cur_req = "R9";
    for (int n = 0; n < 3000; n++) begin
      ld_valid = 1'($urandom); ld_spec = 1'($urandom);
      ld_dst = 7'($urandom % 8); ld_addr = {$urandom, $urandom};
      rsp_v = 1'($urandom); rsp_tag = {1'($urandom), 7'($urandom % 8)};
      rsp_fault = 1'($urandom); rsp_data = {$urandom, $urandom};
      gw_v = ($urandom % 4) == 0; gw_reg = 7'($urandom % 8);
      ck_v = 1'($urandom); ck_reg = 7'($urandom % 8);
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule